// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block folds a wide field of level-sensitive interrupt sources into a much narrower set of parent interrupt lines. Sources are gathered eight at a time into groups, and each group drives exactly one parent line. A parent line stays high as long as at least one enabled source of its group is active. Beside each parent line the block presents the index of the lowest-numbered active enabled source in the group, so a service routine can pick the highest-priority source without scanning.

Software controls the enables through a small register window. Enable bits are raised by writing ones to one address and dropped by writing ones to another, so no read-modify-write is needed and several agents can touch different bits without racing. A third address reports which enabled sources are currently active. Four groups share one 32-bit register bank, and the banks repeat every 16 bytes. Source inputs are asynchronous and pass through a two-stage synchroniser before any masking.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset every enable bit is 0, every parent line is low, every first-index field is 0, and reads of the set and clear words of every bank return 0.
- R2: A write to byte offset 0x0 of a bank sets each enable bit whose wdata bit is 1; enable bits whose wdata bit is 0 keep their value.
- R3: A write to byte offset 0x4 of a bank clears each enable bit whose wdata bit is 1; enable bits whose wdata bit is 0 keep their value.
- R4: Group n lives in the bank at byte address 0x10*floor(n/4), in register bits [8*(n mod 4)+7 : 8*(n mod 4)]; source s (0..7) of group n is src_in[8n+s] and register bit 8*(n mod 4)+s.
- R5: A read of offset 0x0 or 0x4 returns the bank's 32 enable bits; a read of offset 0xC returns the synchronised sources ANDed with the enables; a read of offset 0x8 returns 0.
- R6: parent_irq[n] is high exactly when some source of group n is both active and enabled, and falls once all such sources drop or are disabled.
- R7: With its enable already set, a source that rises is seen on its parent line at the third rising clock edge after the change, and not at the second.
- R8: first_idx[3n+2:3n] holds the lowest s for which source s of group n is active and enabled; it is 0 when the group has none.
- R9: Writes to offsets 0x8 or 0xC, to a bank index at or above the number of banks, or with addr[1:0] not 00 leave every enable bit unchanged; reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_GROUPS*8 | Level interrupt sources, asynchronous |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| parent_irq | output | NUM_GROUPS | One combined interrupt line per group |
| first_idx | output | NUM_GROUPS*3 | Lowest active enabled source index per group |

## Verification
Directed patterns cover reset, a set write with mixed ones and zeros followed by an all-zero write, a clear of a single bit, a source pair inside one mid-range group to separate bank/lane mapping errors from priority errors, and a single source edge timed cycle by cycle to pin the synchroniser depth. Random traffic then interleaves set, clear, ignored and out-of-range writes with random source vectors; comparing all parent lines and first-index fields after every step separates masking faults from priority-encoder faults, while random-bank reads of every offset catch swapped offsets and a status word that skips the enable mask.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int GRP_W     = 8;
    localparam int IDX_W     = $clog2(GRP_W);
    localparam int BANK_W    = 32;
    localparam int GRP_PER_BANK = BANK_W / GRP_W;

    typedef enum logic [1:0] {
        W_SET  = 2'd0,
        W_CLR  = 2'd1,
        W_RSVD = 2'd2,
        W_STAT = 2'd3
    } word_e;

    typedef struct packed {
        logic        hit;
        word_e       word;
        logic [7:0]  bank;
    } reg_req_t;

    function automatic logic [IDX_W-1:0] lowest_set(input logic [GRP_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = GRP_W - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/irqc_enable.sv
module irqc_enable
    import irqc_pkg::*;
#(
    parameter int NUM_SRC   = 160,
    parameter int NUM_BANKS = 5,
    localparam int PAD      = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic [BANK_W-1:0] wdata,
    output logic [PAD-1:0]    en_pad
);
    localparam logic [PAD-1:0] ONE        = PAD'(1);
    localparam logic [PAD-1:0] VALID_MASK = (ONE << NUM_SRC) - ONE;

    logic            in_range;
    logic [PAD-1:0]  nxt;

    assign in_range = req.hit && (int'(req.bank) < NUM_BANKS);

    always_comb begin
        nxt = en_pad;
        if (in_range) begin
            case (req.word)
                W_SET:   nxt[int'(req.bank)*BANK_W +: BANK_W] = en_pad[int'(req.bank)*BANK_W +: BANK_W] | wdata;
                W_CLR:   nxt[int'(req.bank)*BANK_W +: BANK_W] = en_pad[int'(req.bank)*BANK_W +: BANK_W] & ~wdata;
                default: nxt = en_pad;
            endcase
        end
        nxt = nxt & VALID_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) en_pad <= '0;
        else     en_pad <= nxt;
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (en_pad == '0));

    p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        !(in_range && (req.word == W_SET || req.word == W_CLR)) |=> $stable(en_pad));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        localparam logic [BANK_W-1:0] BM = VALID_MASK[b*BANK_W +: BANK_W];
        // R2: ones set, other bits retained
        p_set_r2: assert property (@(posedge clk) disable iff (rst)
            (req.hit && req.bank == 8'(b) && req.word == W_SET) |=>
            (((en_pad[b*BANK_W +: BANK_W] & $past(wdata & BM)) == $past(wdata & BM)) &&
             ((en_pad[b*BANK_W +: BANK_W] & $past(en_pad[b*BANK_W +: BANK_W])) == $past(en_pad[b*BANK_W +: BANK_W]))));
        // R3: ones cleared, other bits retained
        p_clr_r3: assert property (@(posedge clk) disable iff (rst)
            (req.hit && req.bank == 8'(b) && req.word == W_CLR) |=>
            (((en_pad[b*BANK_W +: BANK_W] & $past(wdata)) == '0) &&
             ((en_pad[b*BANK_W +: BANK_W] & ~$past(wdata)) == ($past(en_pad[b*BANK_W +: BANK_W]) & ~$past(wdata)))));
    end
endmodule

// File: rtl/irqc_group.sv
module irqc_group
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [GRP_W-1:0] src_s,
    input  logic [GRP_W-1:0] en,
    output logic             parent_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [GRP_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= src_s & en;
    end

    assign parent_o = |pend_q;
    assign idx_o    = lowest_set(pend_q);

    p_assert_r6: assert property (@(posedge clk) disable iff (rst)
        (|(src_s & en)) |=> parent_o);
    p_deassert_r6: assert property (@(posedge clk) disable iff (rst)
        !(|(src_s & en)) |=> !parent_o);
    p_prio_r8: assert property (@(posedge clk) disable iff (rst)
        parent_o |-> (pend_q[idx_o] && ((pend_q & ((GRP_W'(1) << idx_o) - GRP_W'(1))) == '0)));
    p_idle_idx_r8: assert property (@(posedge clk) disable iff (rst)
        !parent_o |-> (idx_o == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_GROUPS = 20,
    parameter int ADDR_W     = 8,
    localparam int NUM_SRC   = NUM_GROUPS * GRP_W,
    localparam int NUM_BANKS = (NUM_GROUPS + GRP_PER_BANK - 1) / GRP_PER_BANK,
    localparam int PAD       = NUM_BANKS * BANK_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_SRC-1:0]          src_in,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BANK_W-1:0]           wdata,
    output logic [BANK_W-1:0]           rdata,
    output logic [NUM_GROUPS-1:0]       parent_irq,
    output logic [NUM_GROUPS*IDX_W-1:0] first_idx
);
    logic [NUM_SRC-1:0] src_s;
    logic [PAD-1:0]     en_pad;
    logic [PAD-1:0]     src_pad;
    logic               aligned;
    logic               bank_ok;
    reg_req_t           wreq;
    reg_req_t           rreq;

    irqc_sync #(.W(NUM_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_in),
        .q   (src_s)
    );

    assign aligned   = (addr[1:0] == 2'b00);
    assign rreq.hit  = aligned;
    assign rreq.word = word_e'(addr[3:2]);
    assign rreq.bank = 8'(addr[ADDR_W-1:4]);
    assign wreq      = '{hit: aligned && wr_en, word: rreq.word, bank: rreq.bank};
    assign bank_ok   = int'(rreq.bank) < NUM_BANKS;

    irqc_enable #(.NUM_SRC(NUM_SRC), .NUM_BANKS(NUM_BANKS)) u_en (
        .clk    (clk),
        .rst    (rst),
        .req    (wreq),
        .wdata  (wdata),
        .en_pad (en_pad)
    );

    assign src_pad = PAD'(src_s);

    always_comb begin
        rdata = '0;
        if (rreq.hit && bank_ok) begin
            case (rreq.word)
                W_SET, W_CLR: rdata = en_pad[int'(rreq.bank)*BANK_W +: BANK_W];
                W_STAT:       rdata = en_pad[int'(rreq.bank)*BANK_W +: BANK_W] &
                                      src_pad[int'(rreq.bank)*BANK_W +: BANK_W];
                default:      rdata = '0;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        irqc_group u_grp (
            .clk      (clk),
            .rst      (rst),
            .src_s    (src_s[g*GRP_W +: GRP_W]),
            .en       (en_pad[g*GRP_W +: GRP_W]),
            .parent_o (parent_irq[g]),
            .idx_o    (first_idx[g*IDX_W +: IDX_W])
        );
    end

    p_rsvd_read_r5: assert property (@(posedge clk) disable iff (rst)
        (rreq.word == W_RSVD) |-> (rdata == '0));
    p_bad_bank_r9: assert property (@(posedge clk) disable iff (rst)
        (!bank_ok || !aligned) |-> (rdata == '0));
endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    localparam int NG = 20;
    localparam int NS = NG * 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NS-1:0]   src_in = '0;
    logic            wr_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NG-1:0]   parent_irq;
    logic [NG*3-1:0] first_idx;

    logic [NS-1:0]   en_m = '0;
    int              n_chk = 0;
    int              n_fail = 0;
    bit              done = 1'b0;

    always #2 clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .parent_irq(parent_irq), .first_idx(first_idx)
    );

    function automatic logic [NG-1:0] exp_parent();
        logic [NG-1:0] p;
        for (int g = 0; g < NG; g++) p[g] = |(src_in[g*8 +: 8] & en_m[g*8 +: 8]);
        return p;
    endfunction

    function automatic logic [NG*3-1:0] exp_idx();
        logic [NG*3-1:0] r;
        logic [7:0] v;
        r = '0;
        for (int g = 0; g < NG; g++) begin
            v = src_in[g*8 +: 8] & en_m[g*8 +: 8];
            for (int s = 7; s >= 0; s--) if (v[s]) r[g*3 +: 3] = 3'(s);
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int b;
        b = int'(a[7:4]);
        if (a[1:0] != 2'b00 || b >= 5) return '0;
        case (a[3:2])
            2'd0, 2'd1: return en_m[b*32 +: 32];
            2'd3:       return en_m[b*32 +: 32] & src_in[b*32 +: 32];
            default:    return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int b;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        b = int'(a[7:4]);
        if (a[1:0] == 2'b00 && b < 5) begin
            if (a[3:2] == 2'd0) en_m[b*32 +: 32] = en_m[b*32 +: 32] | d;
            if (a[3:2] == 2'd1) en_m[b*32 +: 32] = en_m[b*32 +: 32] & ~d;
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, NS'(rdata), NS'(exp_read(a)));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic out_chk(input string req);
        chk(req, NS'(parent_irq), NS'(exp_parent()));
        chk({req, " idx R8"}, NS'(first_idx), NS'(exp_idx()));
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 parent", NS'(parent_irq), '0);
        chk("R1 idx", NS'(first_idx), '0);
        for (int b = 0; b < 5; b++) rd_chk("R1 read", 8'(b*16));

        // R2: set with mixed bits, then zero write has no effect
        wr(8'h00, 32'h0000_0101);
        rd_chk("R2 set", 8'h00);
        wr(8'h00, 32'h0);
        rd_chk("R2 zero", 8'h04);
        // R3: clear single bit, zero bits retained
        wr(8'h04, 32'h0000_0001);
        rd_chk("R3 clear", 8'h00);

        // R4 / R6 / R8: group 10 = bank 2, bits 23:16
        wr(8'h20, 32'h00FF_0000);
        src_in[83] = 1'b1; src_in[85] = 1'b1;
        settle();
        chk("R4 R6 parent", NS'(parent_irq), NS'(1 << 10));
        chk("R8 idx", NS'(first_idx[30 +: 3]), NS'(3));
        rd_chk("R5 status", 8'h2C);
        rd_chk("R5 rsvd", 8'h28);

        // R9: ignored writes
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h70, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        rd_chk("R9 en", 8'h00);
        rd_chk("R9 en2", 8'h20);
        rd_chk("R9 badbank", 8'h70);
        rd_chk("R9 unaligned", 8'h21);

        // R6: disable drops parent
        wr(8'h24, 32'h00FF_0000);
        settle();
        out_chk("R6 off");

        // R7: latency, group 0 bit 0
        src_in = '0;
        wr(8'h00, 32'h0000_0001);
        settle();
        @(negedge clk);
        src_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 early", NS'(parent_irq[0]), '0);
        @(negedge clk);
        chk("R7 edge3", NS'(parent_irq[0]), NS'(1));

        // random traffic
        for (int it = 0; it < 250; it++) begin
            int op;
            logic [7:0] a;
            op = int'($urandom % 8);
            a = {4'($urandom % 7), 2'($urandom % 4), 2'b00};
            if ((($urandom % 16)) == 0) a[1:0] = 2'b10;
            if (op < 5) wr(a, $urandom);
            else for (int w = 0; w < NS / 32; w++) src_in[w*32 +: 32] = $urandom & $urandom;
            settle();
            out_chk("R6 rand");
            rd_chk("R5 rand", {4'($urandom % 6), 2'($urandom % 4), 2'b00});
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule